// File: doc/BRIEF.md
# Strobe-latched 256x4 static memory

This block models a small static memory whose address is captured by a strobe edge rather than held steady by the bus master. A fast system clock samples every pin. The block then detects the edges of the strobe, the select, the chip-enable and the write line in logic. On the falling edge of the active-low strobe it captures the address and the level of a second, registered chip-enable. That captured level enables or disables the device for the rest of the strobe cycle.

A write window is open while the strobe, the write line and the select are all low and the captured chip-enable is low. The window commits the most recent data word to the captured address on the first rising edge of any of those three lines. Reads present the stored word on the data output together with a separate output-enable. The output-enable is held low whenever the write line is low, so the data output and data input can share one external bus. The memory contents are undefined after reset.

Top module: `latched_sram`

## Requirements
- R1: While reset is active and on the first cycle after it, `dout_oe` is 0 and `dout` is 0. The captured chip-enable resets to its disabled state.
- R2: The address is captured on the falling edge of `strobe_n`. Later changes of `addr` within the same strobe cycle have no effect on which word is read or written.
- R3: If `bank_sel_n` is high when `strobe_n` falls, the whole strobe cycle neither reads nor writes, even if `bank_sel_n` goes low later.
- R4: A write window is open while `strobe_n`, `wr_n` and `sel_n` are low and the captured `bank_sel_n` is low. The window stores to the captured address when the first of `strobe_n`, `wr_n` or `sel_n` rises. With `sel_n` high, nothing is stored.
- R5: `din` may change any number of times while the window is open. Only the last value present before the window closes is stored.
- R6: `wr_n` may stay low across several strobe cycles. Each cycle then stores to its own captured address when `strobe_n` (or `sel_n`) rises.
- R7: Whenever `wr_n` is low, `dout_oe` is 0.
- R8: With `strobe_n` and `sel_n` both high, `dout_oe` is 0. Whenever `dout_oe` is 0, `dout` reads 0.
- R9: When `strobe_n` and `sel_n` are low, the captured `bank_sel_n` is low and `wr_n` is high, `dout_oe` becomes 1 and `dout` shows the word at the captured address. This happens exactly three clock edges after the input change. A word whose window has just closed by `wr_n` rising is shown at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Active-low strobe; falling edge captures address and chip-enable |
| sel_n | input | 1 | Active-low select, not latched |
| bank_sel_n | input | 1 | Active-low chip-enable, captured on strobe fall |
| wr_n | input | 1 | Active-low write; also disables the output |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, 0 while not enabled |
| dout_oe | output | 1 | Output-enable for an external tri-state driver |

## Verification
The hardest case to reach from the ports is a window that closes while a read opens in the same sampled cycle. This happens when `wr_n` rises with strobe and select still low, and the stored word must appear at once without a stale cycle. Every write in the bench that closes through `wr_n` is followed directly by a scoreboard item expecting the new word. Other write operations close through `strobe_n` or `sel_n`. The bench also changes `din` and `addr` mid-window to show that only the captured address and the final data count.

// File: rtl/lsr_pkg.sv
// Shared types for the strobe-latched memory.
// Assumes all control pins are active low.
package lsr_pkg;
    // Sampled control pins after synchronization.
    typedef struct packed {
        logic strobe_n;
        logic sel_n;
        logic bank_n;
        logic wr_n;
    } lsr_ctl_t;

    localparam int CTL_W = 4;
endpackage

// File: rtl/lsr_sync.sv
// Two-flop sampler for a bundle of pins.
// All bits pass through the same depth, so their relative order is preserved.
// Assumes RST_VAL holds the idle level of each bit.
module lsr_sync #(
    parameter int              WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_bits,
    output logic [WIDTH-1:0] out_bits
);
    logic [WIDTH-1:0] stage1;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            // Two-stage sampling of one bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1[gi]   <= RST_VAL[gi];
                    out_bits[gi] <= RST_VAL[gi];
                end else begin
                    stage1[gi]   <= in_bits[gi];
                    out_bits[gi] <= stage1[gi];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lsr_ctrl.sv
// Strobe edge detection, address and chip-enable capture, write window and read enable.
// Assumes sampled inputs arrive aligned from lsr_sync.
// The write commits on the cycle the window closes.
module lsr_ctrl
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lsr_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              oe_q
);
    logic              strobe_prev;
    logic              fall_strobe;
    logic [ADDR_W-1:0] addr_lat, addr_nxt;
    logic              bank_lat, bank_nxt;
    logic              win_now, win_q;
    logic [DATA_W-1:0] hold_data;
    logic              rd_now;

    // Detect a falling strobe and form the next captured values.
    always_comb begin
        fall_strobe = strobe_prev & ~ctl.strobe_n;
        addr_nxt    = fall_strobe ? addr_s     : addr_lat;
        bank_nxt    = fall_strobe ? ctl.bank_n : bank_lat;
        win_now     = ~ctl.strobe_n & ~ctl.wr_n & ~ctl.sel_n & ~bank_nxt;
        rd_now      = ~ctl.strobe_n & ~ctl.sel_n & ~bank_nxt & ctl.wr_n;
    end

    // Capture registers, window state, last data and output-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_prev <= 1'b1;
            addr_lat    <= '0;
            bank_lat    <= 1'b1;
            win_q       <= 1'b0;
            hold_data   <= '0;
            oe_q        <= 1'b0;
        end else begin
            strobe_prev <= ctl.strobe_n;
            addr_lat    <= addr_nxt;
            bank_lat    <= bank_nxt;
            win_q       <= win_now;
            if (win_now) hold_data <= din_s;
            oe_q        <= rd_now;
        end
    end

    // Commit when the window was open and has just closed.
    always_comb begin
        wr_en   = win_q & ~win_now;
        wr_addr = addr_lat;
        wr_data = hold_data;
        rd_addr = addr_nxt;
    end

    // Captured address only moves on a strobe fall (R2).
    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_strobe |=> $stable(addr_lat));
    // A commit only happens in an enabled cycle (R3).
    assert_commit_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !bank_lat);
    // One commit per window (R4).
    assert_single_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    // Reading and an open window never coincide (R7).
    assert_oe_excl_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_q |-> !win_q);
endmodule

// File: rtl/lsr_array.sv
// Word storage with one write port and one registered read port.
// A same-cycle write to the read address is forwarded.
// Assumes the contents are undefined after reset.
module lsr_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store a committed word.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Register the read word, forwarding a coincident commit.
    always_ff @(posedge clk) begin
        if (!rst_n)                            rd_q <= '0;
        else if (wr_en && wr_addr == rd_addr)  rd_q <= wr_data;
        else                                   rd_q <= mem[rd_addr];
    end

    // Committed data is always defined (R4).
    assert_wdata_known_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(wr_data));
endmodule

// File: rtl/latched_sram.sv
// Top of the strobe-latched memory: samples pins, runs control, holds storage
// and gates the output.
// Assumes inputs may be asynchronous to clk.
module latched_sram
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              sel_n,
    input  logic              bank_sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    localparam int BUS_W = ADDR_W + DATA_W + CTL_W;
    localparam logic [BUS_W-1:0] BUS_IDLE = {{(ADDR_W + DATA_W){1'b0}}, {CTL_W{1'b1}}};

    logic [BUS_W-1:0]  raw_bus, syn_bus;
    lsr_ctl_t          ctl_s;
    logic [ADDR_W-1:0] addr_s, wr_addr, rd_addr;
    logic [DATA_W-1:0] din_s, wr_data, rd_q;
    logic              wr_en, oe_q;

    // Bundle pins for common-depth sampling.
    assign raw_bus = {addr, din, strobe_n, sel_n, bank_sel_n, wr_n};

    lsr_sync #(.WIDTH(BUS_W), .RST_VAL(BUS_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .in_bits(raw_bus), .out_bits(syn_bus)
    );

    // Unpack the sampled bundle.
    assign {addr_s, din_s, ctl_s} = syn_bus;

    lsr_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctl(ctl_s), .addr_s(addr_s), .din_s(din_s),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .oe_q(oe_q)
    );

    lsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_q(rd_q)
    );

    // Output gating: zero whenever not enabled.
    assign dout    = oe_q ? rd_q : '0;
    assign dout_oe = oe_q;

    // Write line low three edges ago keeps the output off (R7).
    assert_wr_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(wr_n, 3));
    // Idle strobe and select keep the output off (R8).
    assert_idle_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> !($past(strobe_n, 3) && $past(sel_n, 3)));
    // Output data is zero when disabled (R8).
    assert_zero_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> dout == '0);
endmodule

// File: tb/latched_sram_tb.sv
// Scoreboard bench: driver tasks push expected output items, a monitor pops and compares.
module latched_sram_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e = 1'b1, s1 = 1'b1, s2 = 1'b1, w = 1'b1;
    logic [7:0] a = '0;
    logic [3:0] d = '0;
    logic [3:0] dout;
    logic       dout_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic       oe;
        logic [3:0] data;
        string      tag;
    } exp_t;
    exp_t expq[$];
    event smp_ev;

    always #10 clk = ~clk;

    latched_sram u_dut (
        .clk(clk), .rst_n(rst_n), .strobe_n(e), .sel_n(s1), .bank_sel_n(s2),
        .wr_n(w), .addr(a), .din(d), .dout(dout), .dout_oe(dout_oe)
    );

    // Monitor: compare outputs with the oldest expected item.
    initial begin
        forever begin
            @(smp_ev);
            if (expq.size() > 0) begin
                exp_t it;
                it = expq.pop_front();
                n_tests++;
                if (dout_oe !== it.oe || dout !== it.data) begin
                    n_fail++;
                    $display("FAIL %s: got oe=%b dout=%h, expected oe=%b dout=%h",
                             it.tag, dout_oe, dout, it.oe, it.data);
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic oe, input logic [3:0] data, input string tag);
        exp_t it;
        it.oe = oe; it.data = data; it.tag = tag;
        expq.push_back(it);
        @(negedge clk);
        -> smp_ev;
        #1;
    endtask

    // Write with a chosen closing line: 0 = wr_n, 1 = strobe_n, 2 = sel_n.
    task automatic wr(input logic [7:0] addr, input logic [3:0] data, input int mode, input string tag);
        a = addr; s2 = 1'b0; w = 1'b1;
        cycles(1);
        e = 1'b0;
        cycles(1);
        a = ~addr; s1 = 1'b0;
        cycles(4);
        w = 1'b0; d = ~data;
        cycles(4);
        expect_out(1'b0, 4'h0, {tag, " R7 output off while writing"});
        d = data ^ 4'h5;
        cycles(2);
        d = data;
        cycles(3);
        if (mode == 0) begin
            w = 1'b1;
            cycles(3);
            expect_out(1'b1, data, {tag, " R9 R5 immediate readback"});
            cycles(1);
            e = 1'b1; s1 = 1'b1;
        end else if (mode == 1) begin
            e = 1'b1;
            cycles(4);
            w = 1'b1; s1 = 1'b1;
        end else begin
            s1 = 1'b1;
            cycles(4);
            e = 1'b1; w = 1'b1;
        end
        cycles(4);
    endtask

    task automatic rd(input logic [7:0] addr, input logic [3:0] data, input string tag);
        a = addr; s2 = 1'b0; w = 1'b1;
        cycles(1);
        e = 1'b0; s1 = 1'b0;
        cycles(1);
        a = ~addr;
        cycles(1);
        expect_out(1'b0, 4'h0, {tag, " R9 not yet after two edges"});
        cycles(1);
        expect_out(1'b1, data, {tag, " R9 read at third edge"});
        cycles(3);
        expect_out(1'b1, data, {tag, " R2 latched address held"});
        e = 1'b1; s1 = 1'b1;
        cycles(4);
        expect_out(1'b0, 4'h0, {tag, " R8 idle output off"});
    endtask

    // Watchdog.
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        cycles(4);
        expect_out(1'b0, 4'h0, "R1 reset state");
        rst_n = 1'b1;
        expect_out(1'b0, 4'h0, "R1 first cycle after reset");
        cycles(2);

        wr(8'h00, 4'h5, 0, "R4 close by write line");
        wr(8'hFF, 4'hA, 1, "R4 close by strobe");
        wr(8'h3C, 4'h3, 2, "R4 close by select");
        rd(8'h00, 4'h5, "R4 R5 word 00");
        rd(8'hFF, 4'hA, "R4 word FF");
        rd(8'h3C, 4'h3, "R4 word 3C");

        // R3: chip-enable high at the strobe fall disables the cycle.
        a = 8'h3C; s2 = 1'b1; w = 1'b1;
        cycles(1);
        e = 1'b0;
        cycles(3);
        s2 = 1'b0; s1 = 1'b0; w = 1'b0; d = 4'hF;
        cycles(4);
        w = 1'b1;
        cycles(4);
        expect_out(1'b0, 4'h0, "R3 read disabled");
        e = 1'b1; s1 = 1'b1;
        cycles(4);
        rd(8'h3C, 4'h3, "R3 no store");

        // R4: select high blocks the write.
        a = 8'hFF; s2 = 1'b0; w = 1'b1;
        cycles(1);
        e = 1'b0;
        cycles(1);
        w = 1'b0; d = 4'h9;
        cycles(4);
        w = 1'b1;
        cycles(2);
        e = 1'b1;
        cycles(4);
        rd(8'hFF, 4'hA, "R4 select high blocks write");

        // R6: write line held low across three strobe cycles.
        s2 = 1'b0; s1 = 1'b0; w = 1'b0; d = 4'h0;
        for (int i = 0; i < 3; i++) begin
            a = 8'h10 + 8'(i);
            cycles(2);
            e = 1'b0;
            cycles(4);
            d = 4'(i + 7);
            cycles(4);
            e = 1'b1;
            cycles(4);
        end
        w = 1'b1; s1 = 1'b1;
        cycles(4);
        for (int i = 0; i < 3; i++)
            rd(8'h10 + 8'(i), 4'(i + 7), "R6 held write line");

        wr(8'h00, 4'hC, 1, "R4 overwrite");
        rd(8'h00, 4'hC, "R4 overwrite readback");

        cycles(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule